// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It steps the analog front end through a repeating measurement frame of four phases: auto-zero, input integration, reference de-integration and integrator discharge. Each phase has its own one-hot control output, and these outputs drive the external analog switches. The integrator comparator arrives as an asynchronous level. The block resynchronizes it, uses its sign at the end of input integration to choose the reference polarity, and counts clocks during de-integration until the comparator sign flips.

Each finished conversion produces a sign-and-magnitude reading together with overrange and underrange flags. A one-clock strobe marks the reading, and a busy flag covers the part of the frame in which the input is being measured. After an overrange, the discharge phase is stretched so the saturated integrator can recover. Auto-zero takes up whatever time is left in a fixed-length frame, but never less than a set minimum. A run/hold input lets the converter run freely or park it in auto-zero with the last reading held.

Top module: `dsq_top`

## Requirements
- R1: Phases always follow the order auto-zero, integrate, de-integrate, discharge, then auto-zero again. Exactly one of the four phase outputs is high in every cycle.
- R2: The integrate phase lasts exactly INT_CLKS clocks.
- R3: At the last integrate clock the synchronized comparator level is stored as the polarity (1 = positive input). During de-integrate `ref_neg_o` equals that polarity. The polarity stays constant through de-integrate, and `neg_o` of the reading is its inverse.
- R4: De-integrate ends when the synchronized comparator differs from the stored polarity. If `cmp_i` changes at the sampling point j clocks after de-integrate begins, the reading is j+2 and de-integrate lasts j+3 clocks.
- R5: If no crossing is seen within FULL_SCALE clocks, de-integrate ends after FULL_SCALE clocks. The reading is then FULL_SCALE and `over_o` is 1.
- R6: `under_o` is 1 exactly when a non-overrange reading is below UNDER_LIM.
- R7: Discharge lasts ZI_NORM clocks after a normal conversion and ZI_OVR clocks after an overrange.
- R8: The first auto-zero after reset lasts AZ_MIN clocks, counted from the internal reset release two clocks after `rst_n` rises (so AZ_MIN+2 clocks from the rise). Each later auto-zero lasts FRAME_CLKS minus the clocks spent in integrate, de-integrate and discharge of the previous conversion, and never less than AZ_MIN.
- R9: `busy_o` is high during integrate and de-integrate and low during auto-zero and discharge.
- R10: `strobe_o` is high for only the first discharge clock. The reading and its flags change only at that edge and are held otherwise.
- R11: While `run_i` is low, auto-zero does not end and the reading does not change. In the cycle after `run_i` is seen high with the minimum auto-zero time already spent, integrate begins.
- R12: During reset the block is in auto-zero with busy, strobe, reading, sign and flags all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = convert continuously, 0 = hold in auto-zero |
| cmp_i | input | 1 | Integrator comparator, 1 = output above zero, asynchronous |
| ph_az_o | output | 1 | Auto-zero switch control |
| ph_int_o | output | 1 | Input-integrate switch control |
| ph_de_o | output | 1 | De-integrate switch control |
| ph_zi_o | output | 1 | Integrator-discharge switch control |
| ref_neg_o | output | 1 | During de-integrate: apply the negative reference |
| busy_o | output | 1 | Measurement in progress |
| strobe_o | output | 1 | One-clock pulse marking a new reading |
| count_o | output | $clog2(FULL_SCALE+1) | Magnitude of the reading |
| neg_o | output | 1 | Sign of the reading, 1 = negative |
| over_o | output | 1 | Overrange flag |
| under_o | output | 1 | Underrange flag |

## Verification
The bench runs conversions with a random input sign and a random crossing delay. This separates errors in polarity capture from errors in counting, because the two vary independently. Directed crossings at zero delay, at one below and exactly at the underrange limit, and at the last count before full scale pin down the counting offset and the flag thresholds. Conversions with no crossing test overrange, the stretched discharge and the floored auto-zero. A hold episode shows that the frame stops in auto-zero, keeps the reading unchanged and resumes on the next clock.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2,
    PH_ZI  = 2'd3
  } dsq_phase_e;

endpackage

// File: rtl/dsq_sync.sv
module dsq_sync #(
  parameter int       STAGES  = 2,
  parameter logic     RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign ff_d[s] = d_i;
      end else begin : g_next
        assign ff_d[s] = ff_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/dsq_fsm.sv
module dsq_fsm
  import dsq_pkg::*;
#(
  parameter int FRAME_CLKS = 40000,
  parameter int INT_CLKS   = 10000,
  parameter int FULL_SCALE = 20000,
  parameter int AZ_MIN     = 1000,
  parameter int ZI_NORM    = 150,
  parameter int ZI_OVR     = 6200,
  localparam int M1   = (FRAME_CLKS > ZI_OVR) ? FRAME_CLKS : ZI_OVR,
  localparam int M2   = (FULL_SCALE > INT_CLKS) ? FULL_SCALE : INT_CLKS,
  localparam int MAXC = (M1 > M2) ? M1 : M2,
  localparam int CW   = $clog2(MAXC + 1),
  localparam int RW   = $clog2(FULL_SCALE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          cmp_s_i,
  output dsq_phase_e    phase_o,
  output logic          pol_o,
  output logic          done_o,
  output logic [RW-1:0] res_cnt_o,
  output logic          res_over_o
);

  dsq_phase_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] az_end_q, az_end_d;
  logic          pol_q, pol_d;
  logic          zi_long_q, zi_long_d;
  logic [CW-1:0] zi_end;
  int            de_cyc, zi_cyc, used_cyc, az_len;

  assign zi_end = zi_long_q ? CW'(ZI_OVR - 1) : CW'(ZI_NORM - 1);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    az_end_d   = az_end_q;
    pol_d      = pol_q;
    zi_long_d  = zi_long_q;
    done_o     = 1'b0;
    res_cnt_o  = '0;
    res_over_o = 1'b0;
    de_cyc     = 0;
    zi_cyc     = 0;
    used_cyc   = 0;
    az_len     = AZ_MIN;
    case (state_q)
      PH_AZ: begin
        if (cnt_q >= az_end_q) begin
          if (run_i) begin
            state_d = PH_INT;
            cnt_d   = '0;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_INT: begin
        if (cnt_q == CW'(INT_CLKS - 1)) begin
          state_d = PH_DE;
          cnt_d   = '0;
          pol_d   = cmp_s_i;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DE: begin
        if (cmp_s_i != pol_q) begin
          done_o    = 1'b1;
          res_cnt_o = RW'(cnt_q);
          de_cyc    = int'(cnt_q) + 1;
          zi_cyc    = ZI_NORM;
          zi_long_d = 1'b0;
        end else if (cnt_q == CW'(FULL_SCALE - 1)) begin
          done_o     = 1'b1;
          res_cnt_o  = RW'(FULL_SCALE);
          res_over_o = 1'b1;
          de_cyc     = FULL_SCALE;
          zi_cyc     = ZI_OVR;
          zi_long_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        if (done_o) begin
          state_d  = PH_ZI;
          cnt_d    = '0;
          used_cyc = INT_CLKS + de_cyc + zi_cyc;
          az_len   = (used_cyc + AZ_MIN > FRAME_CLKS) ? AZ_MIN : (FRAME_CLKS - used_cyc);
          az_end_d = CW'(az_len - 1);
        end
      end
      PH_ZI: begin
        if (cnt_q == zi_end) begin
          state_d = PH_AZ;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = PH_AZ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_AZ;
      cnt_q     <= '0;
      az_end_q  <= CW'(AZ_MIN - 1);
      pol_q     <= 1'b1;
      zi_long_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      az_end_q  <= az_end_d;
      pol_q     <= pol_d;
      zi_long_q <= zi_long_d;
    end
  end

  assign phase_o = state_q;
  assign pol_o   = pol_q;

  // R1
  int_after_az_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_INT && $past(state_q) != PH_INT) |-> $past(state_q) == PH_AZ);
  // R1
  de_after_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_DE && $past(state_q) != PH_DE) |-> $past(state_q) == PH_INT);
  // R1
  zi_after_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_ZI && $past(state_q) != PH_ZI) |-> $past(state_q) == PH_DE);
  // R3
  pol_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_DE && $past(state_q) == PH_DE) |-> $stable(pol_q));
  // R11
  hold_az_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_AZ && !run_i) |=> state_q == PH_AZ);

endmodule

// File: rtl/dsq_result.sv
module dsq_result #(
  parameter int FULL_SCALE = 20000,
  parameter int UNDER_LIM  = 1800,
  localparam int RW = $clog2(FULL_SCALE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [RW-1:0] cnt_i,
  input  logic          over_i,
  input  logic          pol_i,
  output logic [RW-1:0] cnt_o,
  output logic          neg_o,
  output logic          over_o,
  output logic          under_o,
  output logic          strobe_o
);

  logic [RW-1:0] cnt_q;
  logic          neg_q, over_q, under_q, strobe_q;
  logic          under_d;

  assign under_d = !over_i && (cnt_i < RW'(UNDER_LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      neg_q   <= 1'b0;
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else if (done_i) begin
      cnt_q   <= cnt_i;
      neg_q   <= !pol_i;
      over_q  <= over_i;
      under_q <= under_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= done_i;
  end

  assign cnt_o    = cnt_q;
  assign neg_o    = neg_q;
  assign over_o   = over_q;
  assign under_o  = under_q;
  assign strobe_o = strobe_q;

  // R10
  held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_q |-> $stable(cnt_q) || $past(done_i));

endmodule

// File: rtl/dsq_top.sv
module dsq_top
  import dsq_pkg::*;
#(
  parameter int FRAME_CLKS = 40000,
  parameter int INT_CLKS   = 10000,
  parameter int FULL_SCALE = 20000,
  parameter int AZ_MIN     = 1000,
  parameter int ZI_NORM    = 150,
  parameter int ZI_OVR     = 6200,
  parameter int UNDER_LIM  = 1800,
  localparam int RW = $clog2(FULL_SCALE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          cmp_i,
  output logic          ph_az_o,
  output logic          ph_int_o,
  output logic          ph_de_o,
  output logic          ph_zi_o,
  output logic          ref_neg_o,
  output logic          busy_o,
  output logic          strobe_o,
  output logic [RW-1:0] count_o,
  output logic          neg_o,
  output logic          over_o,
  output logic          under_o
);

  logic          rst_n_s;
  logic          cmp_s;
  dsq_phase_e    phase;
  logic          pol;
  logic          done;
  logic [RW-1:0] res_cnt;
  logic          res_over;

  dsq_sync #(.STAGES(2), .RST_VAL(1'b0)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_s)
  );

  dsq_sync #(.STAGES(2), .RST_VAL(1'b0)) i_cmp_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(cmp_i), .q_o(cmp_s)
  );

  dsq_fsm #(
    .FRAME_CLKS(FRAME_CLKS), .INT_CLKS(INT_CLKS), .FULL_SCALE(FULL_SCALE),
    .AZ_MIN(AZ_MIN), .ZI_NORM(ZI_NORM), .ZI_OVR(ZI_OVR)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n_s), .run_i(run_i), .cmp_s_i(cmp_s),
    .phase_o(phase), .pol_o(pol), .done_o(done),
    .res_cnt_o(res_cnt), .res_over_o(res_over)
  );

  dsq_result #(.FULL_SCALE(FULL_SCALE), .UNDER_LIM(UNDER_LIM)) i_result (
    .clk(clk), .rst_n(rst_n_s), .done_i(done), .cnt_i(res_cnt),
    .over_i(res_over), .pol_i(pol), .cnt_o(count_o), .neg_o(neg_o),
    .over_o(over_o), .under_o(under_o), .strobe_o(strobe_o)
  );

  assign ph_az_o   = (phase == PH_AZ);
  assign ph_int_o  = (phase == PH_INT);
  assign ph_de_o   = (phase == PH_DE);
  assign ph_zi_o   = (phase == PH_ZI);
  assign busy_o    = ph_int_o || ph_de_o;
  assign ref_neg_o = ph_de_o && pol;

  // R10
  strobe_place_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    strobe_o |-> ph_zi_o && $past(ph_de_o));
  // R5
  over_count_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    over_o |-> count_o == RW'(FULL_SCALE) && !under_o);

endmodule

// File: tb/test_dsq_top.sv
module test_dsq_top;

  localparam int CLK_PERIOD = 10;
  localparam int P_FRAME = 280;
  localparam int P_INT   = 50;
  localparam int P_FS    = 100;
  localparam int P_AZMIN = 20;
  localparam int P_ZIN   = 10;
  localparam int P_ZIO   = 120;
  localparam int P_UNDER = 9;
  localparam int RW      = $clog2(P_FS + 1);

  logic clk = 1'b0;
  logic rst_n, run_i, cmp_i;
  logic ph_az_o, ph_int_o, ph_de_o, ph_zi_o, ref_neg_o, busy_o, strobe_o;
  logic [RW-1:0] count_o;
  logic neg_o, over_o, under_o;

  int checks = 0;
  int errors = 0;
  int exp_az;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsq_top #(
    .FRAME_CLKS(P_FRAME), .INT_CLKS(P_INT), .FULL_SCALE(P_FS), .AZ_MIN(P_AZMIN),
    .ZI_NORM(P_ZIN), .ZI_OVR(P_ZIO), .UNDER_LIM(P_UNDER)
  ) i_dsq_top (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .cmp_i(cmp_i),
    .ph_az_o(ph_az_o), .ph_int_o(ph_int_o), .ph_de_o(ph_de_o), .ph_zi_o(ph_zi_o),
    .ref_neg_o(ref_neg_o), .busy_o(busy_o), .strobe_o(strobe_o), .count_o(count_o),
    .neg_o(neg_o), .over_o(over_o), .under_o(under_o)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int next_az(input int de_cyc, input int zi_cyc);
    int used;
    used = P_INT + de_cyc + zi_cyc;
    return (used + P_AZMIN > P_FRAME) ? P_AZMIN : P_FRAME - used;
  endfunction

  task automatic do_conv(input bit p, input int j, input bit ovr, input bit hold);
    int n;
    int held;
    int exp_cnt;
    cmp_i = p;
    if (hold) begin
      run_i = 1'b0;
      held = int'(count_o);
      for (int k = 0; k < exp_az + 40; k++) @(negedge clk);
      chk(int'(ph_az_o), 1, "R11 parked in auto-zero");
      chk(int'(count_o), held, "R11 reading held");
      chk(int'(strobe_o), 0, "R11 no strobe while parked");
      run_i = 1'b1;
      @(negedge clk);
      chk(int'(ph_int_o), 1, "R11 resume next clock");
    end else begin
      n = 0;
      chk(int'(busy_o), 0, "R9 busy low in auto-zero");
      while (ph_az_o) begin n++; @(negedge clk); end
      chk(n, exp_az, "R8 auto-zero length");
    end
    chk(int'(busy_o), 1, "R9 busy high in integrate");
    n = 0;
    while (ph_int_o) begin n++; @(negedge clk); end
    chk(n, P_INT, "R2 integrate length");
    chk(int'(ph_de_o), 1, "R1 de-integrate follows integrate");
    chk(int'(ref_neg_o), int'(p), "R3 reference steering");
    chk(int'(busy_o), 1, "R9 busy high in de-integrate");
    n = 0;
    while (ph_de_o) begin
      if (!ovr && n == j) cmp_i = ~p;
      n++;
      @(negedge clk);
    end
    exp_cnt = ovr ? P_FS : j + 2;
    chk(n, ovr ? P_FS : j + 3, ovr ? "R5 de-integrate length" : "R4 de-integrate length");
    chk(int'(ph_zi_o), 1, "R1 discharge follows de-integrate");
    chk(int'(strobe_o), 1, "R10 strobe on first discharge clock");
    chk(int'(count_o), exp_cnt, ovr ? "R5 overrange reading" : "R4 reading");
    chk(int'(over_o), int'(ovr), "R5 overrange flag");
    chk(int'(under_o), int'(!ovr && exp_cnt < P_UNDER), "R6 underrange flag");
    chk(int'(neg_o), int'(!p), "R3 reading sign");
    chk(int'(busy_o), 0, "R9 busy low in discharge");
    n = 0;
    while (ph_zi_o) begin
      n++;
      @(negedge clk);
      if (n == 1) chk(int'(strobe_o), 0, "R10 strobe single clock");
    end
    chk(n, ovr ? P_ZIO : P_ZIN, "R7 discharge length");
    chk(int'(ph_az_o), 1, "R1 auto-zero follows discharge");
    exp_az = next_az(ovr ? P_FS : j + 3, ovr ? P_ZIO : P_ZIN);
  endtask

  initial begin
    int j;
    bit p;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    run_i = 1'b1;
    cmp_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(ph_az_o), 1, "R12 reset phase");
    chk(int'(busy_o), 0, "R12 reset busy");
    chk(int'(strobe_o), 0, "R12 reset strobe");
    chk(int'(count_o), 0, "R12 reset reading");
    chk(int'(over_o | under_o | neg_o), 0, "R12 reset flags");
    rst_n = 1'b1;
    exp_az = P_AZMIN + 2;
    do_conv(1'b1, 0, 1'b0, 1'b0);
    do_conv(1'b0, 6, 1'b0, 1'b0);
    do_conv(1'b1, 7, 1'b0, 1'b0);
    do_conv(1'b0, P_FS - 3, 1'b0, 1'b0);
    do_conv(1'b1, 0, 1'b1, 1'b0);
    do_conv(1'b0, 0, 1'b1, 1'b0);
    do_conv(1'b1, 30, 1'b0, 1'b1);
    for (int k = 0; k < 12; k++) begin
      p = 1'($urandom_range(0, 1));
      j = $urandom_range(0, P_FS - 3);
      do_conv(p, j, 1'b0, (k == 5));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule